// File: doc/BRIEF.md
# Virtual Interrupt Acknowledge Unit

This block models the read side of an acknowledge register in a virtual CPU interface. It holds a small table of virtual Group 0 interrupts. Each slot stores an interrupt ID, a priority and a state, which is idle, pending or active. A simple write port loads or clears a slot. The block also keeps a running-priority register, and a separate input lets other logic overwrite it. An external priority mask is applied on every cycle.

A one-cycle read strobe returns a registered 32-bit word one cycle later. That word names the best pending interrupt, provided it is allowed to be signalled. The same read acknowledges that interrupt: its slot moves from pending to active, and the running priority takes on its priority. When nothing can be signalled, the word carries the special ID 1023. The interrupt-signal output is computed from the registered state. It therefore reflects the completed acknowledge in the same cycle that the read response appears.

Top module: `vack_unit`

## Requirements
- R1: A read selects the pending slot with the numerically lowest priority value. When several slots share that priority, the slot with the lowest index is selected.
- R2: The selected slot is reported only if its priority is strictly below both `pmr` and the running priority. Otherwise the word returns 1023 and no state changes.
- R3: A reported slot becomes active and is never reported again until the write port rewrites it. The running priority takes on that slot's priority.
- R4: `rd_data[31:24]` always reads zero. `rd_data[23:0]` carries the ID.
- R5: The `id_wide` value in the strobe cycle selects the ID width. With `id_wide`=1 the full 24-bit ID is returned. With `id_wide`=0, bits 23:16 read zero and only ID bits 15:0 are returned.
- R6: `rd_valid` is high for exactly the cycle after each strobe, together with the new `rd_data`. At all other times it is low.
- R7: `irq_out` is high exactly when a read in that cycle would report a slot. It reflects the post-acknowledge state in the same cycle that `rd_valid` rises.
- R8: `wr_en` with `wr_pend`=1 loads `wr_id` and `wr_prio` into slot `wr_slot` as pending. With `wr_pend`=0 the slot becomes idle. A write takes effect after a same-cycle acknowledge, so the write wins for that slot.
- R9: `rpr_load` overwrites the running priority with `rpr_in`. An acknowledge in the same cycle overrides the load.
- R10: After reset, all slots are idle, the running priority is all ones, `rd_data` is 0, and both `rd_valid` and `irq_out` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Slot write strobe |
| wr_slot | input | 3 | Slot index to write |
| wr_pend | input | 1 | 1 loads the slot as pending, 0 makes it idle |
| wr_id | input | 24 | Interrupt ID to store |
| wr_prio | input | 8 | Priority to store (lower value means more urgent) |
| pmr | input | 8 | Priority mask |
| rpr_load | input | 1 | Overwrite the running priority |
| rpr_in | input | 8 | Value for the running-priority overwrite |
| id_wide | input | 1 | 1 selects 24-bit IDs, 0 selects 16-bit IDs |
| rd_strobe | input | 1 | Acknowledge read request |
| rd_data | output | 32 | Registered read word |
| rd_valid | output | 1 | Read word valid |
| irq_out | output | 1 | Virtual interrupt signal |
| run_prio | output | 8 | Current running priority |

## Verification
Three actions can land in the same cycle: an acknowledge read, a write to the very slot that read is choosing, and a running-priority overwrite. The bench provokes each combination. Directed steps load a slot, then read it while rewriting that slot, and separately read while loading the running priority. Random steps mix all three with ties and masking. A bench model applies the order the requirements fix: the selection uses the old table, then the acknowledge is applied, then the write. The bench judges the result by the returned word, the running priority and a later read of the rewritten slot.

// File: rtl/vack_pkg.sv
package vack_pkg;
    typedef enum logic [1:0] {
        SL_IDLE = 2'd0,
        SL_PEND = 2'd1,
        SL_ACT  = 2'd2
    } slot_st_e;

    localparam int unsigned WORD_W      = 32;
    localparam int unsigned ID_W        = 24;
    localparam int unsigned NARROW_W    = 16;
    localparam int unsigned SPURIOUS_ID = 1023;
endpackage

// File: rtl/vack_select.sv
module vack_select #(
    parameter int unsigned N      = 8,
    parameter int unsigned PRIO_W = 8,
    parameter int unsigned IDX_W  = $clog2(N)
) (
    input  logic [N-1:0]             pend,
    input  logic [N-1:0][PRIO_W-1:0] prio,
    input  logic [PRIO_W-1:0]        pmr,
    input  logic [PRIO_W-1:0]        rpr,
    output logic [IDX_W-1:0]         idx,
    output logic [PRIO_W-1:0]        best,
    output logic                     elig
);
    logic found;

    // Strict compare keeps the lowest index on a tie.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '1;
        for (int i = 0; i < int'(N); i++) begin
            if (pend[i] && (!found || prio[i] < best)) begin
                found = 1'b1;
                idx   = IDX_W'(i);
                best  = prio[i];
            end
        end
        elig = found && (best < pmr) && (best < rpr);
    end
endmodule

// File: rtl/vack_fmt.sv
module vack_fmt
    import vack_pkg::*;
(
    input  logic              ok,
    input  logic              wide,
    input  logic [ID_W-1:0]   id,
    output logic [WORD_W-1:0] word
);
    logic [ID_W-1:0] id_eff;

    always_comb begin
        id_eff = wide ? id : {{(ID_W-NARROW_W){1'b0}}, id[NARROW_W-1:0]};
        if (ok) begin
            word = {{(WORD_W-ID_W){1'b0}}, id_eff};
        end else begin
            word = WORD_W'(SPURIOUS_ID);
        end
    end
endmodule

// File: rtl/vack_unit.sv
module vack_unit
    import vack_pkg::*;
#(
    parameter int unsigned N_SLOTS = 8,
    parameter int unsigned PRIO_W  = 8,
    parameter int unsigned SLOT_W  = $clog2(N_SLOTS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SLOT_W-1:0]  wr_slot,
    input  logic               wr_pend,
    input  logic [23:0]        wr_id,
    input  logic [PRIO_W-1:0]  wr_prio,
    input  logic [PRIO_W-1:0]  pmr,
    input  logic               rpr_load,
    input  logic [PRIO_W-1:0]  rpr_in,
    input  logic               id_wide,
    input  logic               rd_strobe,
    output logic [31:0]        rd_data,
    output logic               rd_valid,
    output logic               irq_out,
    output logic [PRIO_W-1:0]  run_prio
);
    typedef struct packed {
        logic [N_SLOTS-1:0][1:0]        st;
        logic [N_SLOTS-1:0][ID_W-1:0]   id;
        logic [N_SLOTS-1:0][PRIO_W-1:0] prio;
        logic [PRIO_W-1:0]              rpr;
        logic [WORD_W-1:0]              rdata;
        logic                           rvalid;
    } regs_t;

    regs_t q, d;

    logic [N_SLOTS-1:0] pend;
    logic [SLOT_W-1:0]  sel_idx;
    logic [PRIO_W-1:0]  sel_prio;
    logic               sel_ok;
    logic [WORD_W-1:0]  word;

    for (genvar g = 0; g < int'(N_SLOTS); g++) begin : g_pend
        assign pend[g] = (q.st[g] == SL_PEND);
    end

    vack_select #(
        .N      (N_SLOTS),
        .PRIO_W (PRIO_W),
        .IDX_W  (SLOT_W)
    ) u_sel (
        .pend (pend),
        .prio (q.prio),
        .pmr  (pmr),
        .rpr  (q.rpr),
        .idx  (sel_idx),
        .best (sel_prio),
        .elig (sel_ok)
    );

    vack_fmt u_fmt (
        .ok   (sel_ok),
        .wide (id_wide),
        .id   (q.id[sel_idx]),
        .word (word)
    );

    // Order: overwrite, then acknowledge, then slot write.
    always_comb begin
        d        = q;
        d.rvalid = 1'b0;
        if (rpr_load) begin
            d.rpr = rpr_in;
        end
        if (rd_strobe) begin
            d.rvalid = 1'b1;
            d.rdata  = word;
            if (sel_ok) begin
                d.st[sel_idx] = SL_ACT;
                d.rpr         = sel_prio;
            end
        end
        if (wr_en) begin
            d.st[wr_slot]   = wr_pend ? SL_PEND : SL_IDLE;
            d.id[wr_slot]   = wr_id;
            d.prio[wr_slot] = wr_prio;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st     <= '0;
            q.id     <= '0;
            q.prio   <= '0;
            q.rpr    <= '1;
            q.rdata  <= '0;
            q.rvalid <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign rd_data  = q.rdata;
    assign rd_valid = q.rvalid;
    assign irq_out  = sel_ok;
    assign run_prio = q.rpr;
endmodule

// File: rtl/vack_unit_chk.sv
module vack_unit_chk #(
    parameter int unsigned PRIO_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_strobe,
    input logic              id_wide,
    input logic              irq_out,
    input logic              rd_valid,
    input logic [31:0]       rd_data,
    input logic [PRIO_W-1:0] run_prio
);
    a_r4_top_byte_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> rd_data[31:24] == 8'h00);

    a_r5_narrow_mask: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe && !id_wide |=> rd_data[23:16] == 8'h00);

    a_r6_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> rd_valid);

    a_r6_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe |=> !rd_valid);

    a_r2_special_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe && !irq_out |=> rd_data == 32'd1023);

    a_r3_rpr_tightens: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe && irq_out |=> run_prio < $past(run_prio));

    a_r7_irq_needs_headroom: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> run_prio != '0);
endmodule

bind vack_unit vack_unit_chk #(.PRIO_W(PRIO_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_strobe (rd_strobe),
    .id_wide   (id_wide),
    .irq_out   (irq_out),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .run_prio  (run_prio)
);

// File: tb/vack_unit_test.sv
module vack_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_slot = '0;
    logic        wr_pend = 1'b0;
    logic [23:0] wr_id = '0;
    logic [7:0]  wr_prio = '0;
    logic [7:0]  pmr = 8'hFF;
    logic        rpr_load = 1'b0;
    logic [7:0]  rpr_in = '0;
    logic        id_wide = 1'b1;
    logic        rd_strobe = 1'b0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic        irq_out;
    logic [7:0]  run_prio;

    int checks = 0;
    int errors = 0;

    logic [1:0]  m_st   [8];
    logic [23:0] m_id   [8];
    logic [7:0]  m_prio [8];
    logic [7:0]  m_rpr;

    always #4 clk = ~clk;

    vack_unit uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_slot(wr_slot),
        .wr_pend(wr_pend), .wr_id(wr_id), .wr_prio(wr_prio), .pmr(pmr),
        .rpr_load(rpr_load), .rpr_in(rpr_in), .id_wide(id_wide),
        .rd_strobe(rd_strobe), .rd_data(rd_data), .rd_valid(rd_valid),
        .irq_out(irq_out), .run_prio(run_prio)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int pick();
        int b = -1;
        for (int i = 0; i < 8; i++)
            if (m_st[i] == 2'd1 && (b < 0 || m_prio[i] < m_prio[b])) b = i;
        if (b >= 0 && !(m_prio[b] < pmr && m_prio[b] < m_rpr)) b = -1;
        return b;
    endfunction

    function automatic logic [31:0] exp_word(int sel, bit wide);
        if (sel < 0) return 32'd1023;
        return wide ? {8'h0, m_id[sel]} : {16'h0, m_id[sel][15:0]};
    endfunction

    // Called at a falling edge; returns at the next falling edge after checking.
    task automatic step(bit we, int slot, bit pend, logic [23:0] id, logic [7:0] pr,
                        bit rl, logic [7:0] rv, bit rd, bit wide, string tag);
        int sel;
        logic [31:0] ew;
        wr_en = we; wr_slot = 3'(slot); wr_pend = pend; wr_id = id; wr_prio = pr;
        rpr_load = rl; rpr_in = rv; rd_strobe = rd; id_wide = wide;
        sel = pick();
        ew  = exp_word(sel, wide);
        if (rl) m_rpr = rv;
        if (rd && sel >= 0) begin
            m_st[sel] = 2'd2;
            m_rpr = m_prio[sel];
        end
        if (we) begin
            m_st[slot] = pend ? 2'd1 : 2'd0;
            m_id[slot] = id;
            m_prio[slot] = pr;
        end
        @(negedge clk);
        wr_en = 1'b0; rpr_load = 1'b0; rd_strobe = 1'b0;
        chk(tag, 32'(rd_valid), 32'(rd));
        if (rd) chk(tag, rd_data, ew);
        chk(tag, 32'(irq_out), 32'(pick() >= 0));
        chk(tag, 32'(run_prio), 32'(m_rpr));
    endtask

    task automatic wr(int slot, logic [23:0] id, logic [7:0] pr, string tag);
        step(1, slot, 1, id, pr, 0, 0, 0, 1, tag);
    endtask

    task automatic rd(bit wide, string tag);
        step(0, 0, 0, 0, 0, 0, 0, 1, wide, tag);
    endtask

    task automatic setrpr(logic [7:0] v, string tag);
        step(0, 0, 0, 0, 0, 1, v, 0, 1, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R6 watchdog actual=timeout expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_st[i] = 2'd0; m_id[i] = '0; m_prio[i] = '0;
        end
        m_rpr = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        chk("R10 rd_data", rd_data, 32'h0);
        chk("R10 rd_valid", 32'(rd_valid), 32'h0);
        chk("R10 irq_out", 32'(irq_out), 32'h0);
        chk("R10 run_prio", 32'(run_prio), 32'hFF);

        rd(1, "R2 empty table");
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, "R6 idle no valid");

        // R1 tie: slot1 beats slot3 at equal priority
        wr(3, 24'h123456, 8'd5, "R8 load");
        wr(1, 24'h000777, 8'd5, "R8 load");
        rd(1, "R1 tie lowest slot");
        rd(1, "R2 equal to running prio");
        rd(1, "R3 active not re-reported");
        setrpr(8'hFF, "R9 overwrite");
        rd(1, "R3 second slot after overwrite");
        rd(1, "R3 both active");

        // R5 narrow IDs
        setrpr(8'hFF, "R9 overwrite");
        wr(0, 24'hAB1234, 8'd1, "R8 load");
        rd(0, "R5 narrow mask");
        setrpr(8'hFF, "R9 overwrite");
        wr(0, 24'hAB1234, 8'd1, "R8 reload");
        rd(1, "R4 wide id");

        // R2 mask boundary
        setrpr(8'hFF, "R9 overwrite");
        pmr = 8'd4;
        wr(2, 24'h00BEEF, 8'd4, "R7 masked no irq");
        rd(1, "R2 prio equal to mask");
        pmr = 8'd5;
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, "R7 irq after mask opens");
        rd(1, "R2 prio below mask");
        pmr = 8'hFF;

        // R8 concurrent write to the chosen slot
        setrpr(8'hFF, "R9 overwrite");
        wr(4, 24'h0C0FFE, 8'd0, "R8 load");
        step(1, 4, 1, 24'h0D00D0, 8'd0, 0, 0, 1, 1, "R8 write wins over ack");
        setrpr(8'hFF, "R9 overwrite");
        rd(1, "R8 rewritten slot returned");
        wr(4, 24'h000444, 8'd3, "R8 load");
        step(1, 4, 0, 24'h0, 8'd0, 0, 0, 0, 1, "R8 clear");
        setrpr(8'hFF, "R9 overwrite");
        rd(1, "R8 cleared slot silent");

        // R9 overwrite and ack same cycle
        wr(5, 24'h055555, 8'd1, "R8 load");
        step(0, 0, 0, 0, 0, 1, 8'd3, 1, 1, "R9 ack overrides load");
        setrpr(8'hFF, "R7 irq drop check");

        // Random mix
        void'($urandom(32'd20240611));
        for (int n = 0; n < 600; n++) begin
            int r = int'($urandom_range(0, 99));
            logic [23:0] id = 24'($urandom);
            if (id == 24'd1023) id = 24'd1024;
            if (r < 8) pmr = 8'($urandom_range(0, 16));
            else if (r < 14) pmr = 8'hFF;
            step($urandom_range(0, 1) == 1, int'($urandom_range(0, 7)),
                 $urandom_range(0, 4) != 0, id, 8'($urandom_range(0, 15)),
                 $urandom_range(0, 5) == 0, 8'($urandom_range(0, 17)) | 8'($urandom_range(0, 3) == 0 ? 8'hF0 : 8'h00),
                 $urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1,
                 "R1 R3 R7 random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule